// File: doc/BRIEF.md
# Selectable-Constant Adder/Subtractor

This block adds a constant to a W-bit operand, or subtracts that constant from it. The constant is one of four chosen when the block is built. All four constants are module parameters. Two select inputs pick which one applies at run time, and a mode input picks addition or subtraction. The mode and both select lines are shared by every bit position.

The datapath is a ripple-carry column of identical one-bit slices, running from bit 0 up to bit W-1. Each slice works as follows:

- It takes its bit of the selected constant.
- In subtract mode it inverts that bit.
- It forms a propagate term with the operand bit.
- It produces a sum bit and a carry through a 2:1 carry multiplexer.

The mode bit also drives the carry into bit 0, so subtraction is ordinary two's-complement arithmetic. The block is purely combinational and holds no state.

Top module: `addsub_const4`

## Requirements
- R1: The selected constant is K0 when {sel1_i, sel0_i} = 2'b00, K1 for 2'b01, K2 for 2'b10 and K3 for 2'b11. sel0_i chooses within a pair and sel1_i chooses the pair.
- R2: With sub_i = 0, res_o equals (opd_i + selected constant) modulo 2^W.
- R3: With sub_i = 0, cout_o equals bit W of the unsigned (W+1)-bit sum opd_i + selected constant.
- R4: With sub_i = 1, res_o equals (opd_i - selected constant) modulo 2^W, computed as opd_i + ~K + 1.
- R5: With sub_i = 1, cout_o is 1 exactly when opd_i >= selected constant (unsigned), meaning no borrow.
- R6: With sub_i = 1 and opd_i equal to the selected constant, res_o is zero and cout_o is 1.
- R7: With a zero constant selected, res_o equals opd_i in both modes. cout_o is 0 when adding and 1 when subtracting.
- R8: The outputs depend only on the present inputs. A change on any input shows on res_o and cout_o without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_i | input | W | Operand |
| sub_i | input | 1 | Mode: 0 add, 1 subtract; also carry into bit 0 |
| sel0_i | input | 1 | Select within a constant pair |
| sel1_i | input | 1 | Select between the two constant pairs |
| res_o | output | W | Result modulo 2^W |
| cout_o | output | 1 | Carry out of the top bit |

## Verification
The bench builds the block with W = 8 and sets the four constants to 8'h00, 8'hFF, 8'h80 and 8'h5A. These values cover three edge cases:

- The zero constant reaches the identity case of R7.
- The all-ones constant makes the carry ripple the full length of the chain in both modes.
- 8'h80 sits on the sign boundary, so the borrow decision of R5 turns on the top bit alone.

The operands include 0, all ones, values either side of the MSB boundary, each constant itself, and seeded random values. Every operand is tried under all eight mode and select combinations.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        MODE_ADD = 1'b0,
        MODE_SUB = 1'b1
    } addsub_mode_e;

    typedef struct packed {
        logic sum;
        logic carry;
    } slice_out_t;

    typedef struct packed {
        logic sel1;
        logic sel0;
    } const_sel_t;

    // Pick one of four bits: sel0 inside a pair, sel1 across the pairs.
    function automatic logic pick4(input const_sel_t sel,
                                   input logic b0, input logic b1,
                                   input logic b2, input logic b3);
        logic lo_pair;
        logic hi_pair;
        lo_pair = sel.sel0 ? b1 : b0;
        hi_pair = sel.sel0 ? b3 : b2;
        return sel.sel1 ? hi_pair : lo_pair;
    endfunction

endpackage

// File: rtl/const_select.sv
module const_select
    import addsub_pkg::*;
#(
    parameter int          W  = 16,
    parameter logic [W-1:0] K0 = '0,
    parameter logic [W-1:0] K1 = '0,
    parameter logic [W-1:0] K2 = '0,
    parameter logic [W-1:0] K3 = '0
) (
    input  const_sel_t     sel_i,
    output logic [W-1:0]   kbits_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_comb begin
            kbits_o[i] = pick4(sel_i, K0[i], K1[i], K2[i], K3[i]);
        end
    end

endmodule

// File: rtl/addsub_slice.sv
module addsub_slice
    import addsub_pkg::*;
(
    input  logic        opd_bit_i,
    input  logic        k_bit_i,
    input  addsub_mode_e mode_i,
    input  logic        cin_i,
    output slice_out_t  out_o
);

    logic k_eff;
    logic prop;

    always_comb begin
        k_eff       = k_bit_i ^ (mode_i == MODE_SUB);
        prop        = opd_bit_i ^ k_eff;
        out_o.sum   = prop ^ cin_i;
        out_o.carry = prop ? cin_i : opd_bit_i;
    end

endmodule

// File: rtl/addsub_const4.sv
module addsub_const4
    import addsub_pkg::*;
#(
    parameter int          W  = 16,
    parameter logic [W-1:0] K0 = 16'h0000,
    parameter logic [W-1:0] K1 = 16'hFFFF,
    parameter logic [W-1:0] K2 = 16'h8000,
    parameter logic [W-1:0] K3 = 16'h1234
) (
    input  logic [W-1:0] opd_i,
    input  logic         sub_i,
    input  logic         sel0_i,
    input  logic         sel1_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);

    localparam int CW = W + 1;

    const_sel_t   sel;
    addsub_mode_e mode;
    logic [W-1:0] kbits;
    logic [CW-1:0] carry;
    slice_out_t   slice_out [W];

    always_comb begin
        sel.sel0 = sel0_i;
        sel.sel1 = sel1_i;
        mode     = sub_i ? MODE_SUB : MODE_ADD;
        carry[0] = sub_i;
    end

    const_select #(
        .W (W), .K0(K0), .K1(K1), .K2(K2), .K3(K3)
    ) u_sel (
        .sel_i   (sel),
        .kbits_o (kbits)
    );

    for (genvar i = 0; i < W; i++) begin : g_slice
        addsub_slice u_slice (
            .opd_bit_i (opd_i[i]),
            .k_bit_i   (kbits[i]),
            .mode_i    (mode),
            .cin_i     (carry[i]),
            .out_o     (slice_out[i])
        );
        always_comb begin
            res_o[i]   = slice_out[i].sum;
            carry[i+1] = slice_out[i].carry;
        end
    end

    assign cout_o = carry[W];

endmodule

// File: rtl/addsub_const4_chk.sv
module addsub_const4_chk #(
    parameter int          W  = 16,
    parameter logic [W-1:0] K0 = '0,
    parameter logic [W-1:0] K1 = '0,
    parameter logic [W-1:0] K2 = '0,
    parameter logic [W-1:0] K3 = '0
) (
    input logic [W-1:0] opd_i,
    input logic         sub_i,
    input logic         sel0_i,
    input logic         sel1_i,
    input logic [W-1:0] res_o,
    input logic         cout_o
);

    logic [W-1:0] k_ref;
    logic [W:0]   add_ref;
    logic [W:0]   sub_ref;
    logic         known;

    always_comb begin
        case ({sel1_i, sel0_i})
            2'b00:   k_ref = K0;
            2'b01:   k_ref = K1;
            2'b10:   k_ref = K2;
            default: k_ref = K3;
        endcase
        add_ref = {1'b0, opd_i} + {1'b0, k_ref};
        sub_ref = {1'b0, opd_i} - {1'b0, k_ref};
        known   = !$isunknown({opd_i, sub_i, sel0_i, sel1_i, res_o, cout_o});
    end

    always_comb begin
        if (known && !sub_i) begin
            p_add_sum_r2: assert (res_o == add_ref[W-1:0]);
            p_add_carry_r3: assert (cout_o == add_ref[W]);
        end
        if (known && sub_i) begin
            p_sub_diff_r4: assert (res_o == sub_ref[W-1:0]);
            p_sub_noborrow_r5: assert (cout_o == (opd_i >= k_ref));
        end
        if (known && sub_i && (opd_i == k_ref)) begin
            p_equal_zero_r6: assert (res_o == '0 && cout_o);
        end
    end

endmodule

bind addsub_const4 addsub_const4_chk #(
    .W (W), .K0(K0), .K1(K1), .K2(K2), .K3(K3)
) u_chk (.*);

// File: tb/addsub_const4_bench.sv
module addsub_const4_bench;

    localparam int          W  = 8;
    localparam logic [W-1:0] K0 = 8'h00;
    localparam logic [W-1:0] K1 = 8'hFF;
    localparam logic [W-1:0] K2 = 8'h80;
    localparam logic [W-1:0] K3 = 8'h5A;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] opd;
    logic         sub;
    logic         sel0;
    logic         sel1;
    logic [W-1:0] res;
    logic         cout;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    addsub_const4 #(
        .W (W), .K0(K0), .K1(K1), .K2(K2), .K3(K3)
    ) u_addsub_const4 (
        .opd_i  (opd),
        .sub_i  (sub),
        .sel0_i (sel0),
        .sel1_i (sel1),
        .res_o  (res),
        .cout_o (cout)
    );

    function automatic logic [W-1:0] const_of(input logic [1:0] s);
        case (s)
            2'b00:   return K0;
            2'b01:   return K1;
            2'b10:   return K2;
            default: return K3;
        endcase
    endfunction

    // Behavioural model: opd + (sub ? ~K : K) + sub, W+1 bits.
    function automatic logic [W:0] model(input logic [W-1:0] a, input logic s,
                                         input logic [1:0] sl);
        logic [W-1:0] k;
        k = const_of(sl);
        if (s) k = ~k;
        return {1'b0, a} + {1'b0, k} + {{W{1'b0}}, s};
    endfunction

    task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s opd=%h sub=%b sel=%b%b actual=%h expected=%h",
                     req, opd, sub, sel1, sel0, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] a, input logic s, input logic [1:0] sl);
        @(posedge clk);
        opd  = a;
        sub  = s;
        {sel1, sel0} = sl;
        @(negedge clk);
    endtask

    task automatic check_all(input logic [W-1:0] a);
        for (int m = 0; m < 2; m++) begin
            for (int sl = 0; sl < 4; sl++) begin
                logic [W:0] exp;
                logic [W-1:0] k;
                apply(a, m[0], sl[1:0]);
                exp = model(a, m[0], sl[1:0]);
                k   = const_of(sl[1:0]);
                if (m == 0) begin
                    check("R2", {1'b0, res}, {1'b0, exp[W-1:0]});
                    check("R3", {{W{1'b0}}, cout}, {{W{1'b0}}, exp[W]});
                end else begin
                    check("R4", {1'b0, res}, {1'b0, a - k});
                    check("R5", {{W{1'b0}}, cout}, {{W{1'b0}}, a >= k});
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed_draw;
        seed_draw = $urandom(32'd4711);
        opd = '0; sub = 1'b0; sel0 = 1'b0; sel1 = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Initial state: zero operand, add, K0 -> zero result, no carry (R7).
        check("R7", {cout, res}, {1'b0, 8'h00});

        // R1: select encoding, observed through add with zero operand.
        for (int sl = 0; sl < 4; sl++) begin
            apply('0, 1'b0, sl[1:0]);
            check("R1", {1'b0, res}, {1'b0, const_of(sl[1:0])});
        end

        // R7: zero constant is identity in both modes.
        apply(8'hA7, 1'b0, 2'b00);
        check("R7", {cout, res}, {1'b0, 8'hA7});
        apply(8'hA7, 1'b1, 2'b00);
        check("R7", {cout, res}, {1'b1, 8'hA7});

        // R6: operand equal to constant in subtract mode.
        for (int sl = 0; sl < 4; sl++) begin
            apply(const_of(sl[1:0]), 1'b1, sl[1:0]);
            check("R6", {cout, res}, {1'b1, 8'h00});
        end

        // R3: full-length carry ripple, 0x01 + 0xFF.
        apply(8'h01, 1'b0, 2'b01);
        check("R3", {cout, res}, {1'b1, 8'h00});

        // R5: MSB boundary borrow around 0x80.
        apply(8'h7F, 1'b1, 2'b10);
        check("R5", {cout, res}, {1'b0, 8'hFF});
        apply(8'h80, 1'b1, 2'b10);
        check("R5", {cout, res}, {1'b1, 8'h00});

        // R8: input change seen without a clock edge.
        @(posedge clk);
        #1;
        opd = 8'h10; sub = 1'b0; sel0 = 1'b1; sel1 = 1'b1;
        #0.5;
        check("R8", {cout, res}, {1'b0, 8'h6A});
        sub = 1'b1;
        #0.5;
        check("R8", {cout, res}, {1'b0, 8'hB6});

        // Edge operands across all modes and selects.
        check_all(8'h00);
        check_all(8'hFF);
        check_all(8'h7F);
        check_all(8'h80);
        check_all(8'h81);
        check_all(8'h5A);
        check_all(8'h01);

        // Seeded random operands.
        for (int n = 0; n < 300; n++) begin
            check_all(W'($urandom));
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule